// File: doc/BRIEF.md
# Instrument Bus Talker/Listener Status Detector

This block sits beside the 8-line parallel instrument bus of a plug-in card and decides when the host has addressed the card as a listener or as a talker. Whenever the attention qualifier marks the current byte as a command, the low five data lines are compared with a 5-bit primary address from the card's configuration switches. On a match, the two role lines (data lines 6 and 5) select a listen assignment or a talk assignment. Command byte bit 7 plays no part in the decision, so only the seven relevant lines are brought into the block.

A listen assignment sets a listener flag and sends a timed active-low acknowledge pulse. A talk assignment sets a talker flag, drives a separate active-low copy of it that enables the card's bus data driver, and holds an active-low talk acknowledge until the command byte is withdrawn. Each flag has its own clear source. An unlisten strobe drops the listener flag. The local controller's untalk request drops the talker flag. A bus reset drops both.

All bus-side inputs are asynchronous. Each one passes through a two-stage synchroniser, and an edge detector turns it into a one-cycle event. The block has no streaming data path, so every pin is a plain control or status level.

Top module: `talk_listen_detect`

## Requirements
- R1: After reset, `listen_o` and `talk_o` are 0, and `talk_n_o`, `listen_ack_n_o` and `talk_ack_n_o` are 1.
- R2: A rising edge of `cmd_qual_i` with `cmd_lines_i[4:0]` equal to `my_addr_i` and `cmd_lines_i[6:5]` = 2'b01 sets `listen_o`.
- R3: The cycle `listen_o` is assigned, `listen_ack_n_o` goes low and stays low for exactly ACK_CYCLES clock cycles.
- R4: A rising edge of `cmd_qual_i` with a matching address and `cmd_lines_i[6:5]` = 2'b10 sets `talk_o` and drives `talk_n_o` low.
- R5: `talk_ack_n_o` goes low together with a talk assignment. It returns high on the falling edge of `cmd_qual_i`, or on whatever clears the talker flag.
- R6: The flags keep their values in three cases: a command whose address differs, a command whose role code is 2'b00 or 2'b11, and data lines that change while `cmd_qual_i` stays low.
- R7: A rising edge of `unlisten_i` clears `listen_o` and does not change `talk_o`.
- R8: A falling edge of `bus_rst_n_i` clears both flags, so `talk_n_o` goes high.
- R9: A rising edge of `untalk_i` clears `talk_o`, raises `talk_n_o` and releases `talk_ack_n_o`, and does not change `listen_o`.
- R10: Each flag or acknowledge change appears after the third rising clock edge that follows the input change. When a clear and a set for the same flag fall in the same cycle, the clear wins.
- R11: `talk_n_o` is always the complement of `talk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_addr_i | input | 5 | Primary address from configuration switches (static) |
| cmd_lines_i | input | 7 | Bus data lines 0 to 6 (asynchronous) |
| cmd_qual_i | input | 1 | Attention/data-valid qualifier, high marks a command byte |
| unlisten_i | input | 1 | Unlisten strobe, active high |
| bus_rst_n_i | input | 1 | Bus reset, active low |
| untalk_i | input | 1 | Local untalk request, active high |
| listen_o | output | 1 | Listener flag |
| talk_o | output | 1 | Talker flag |
| talk_n_o | output | 1 | Active-low talker flag, enables the bus data driver |
| listen_ack_n_o | output | 1 | Active-low listen acknowledge pulse |
| talk_ack_n_o | output | 1 | Active-low talk acknowledge |

## Verification
The two synchroniser stages and the output register put every result on the third rising edge after an input moves. The bench therefore drives each stimulus at a falling edge, waits three rising edges and samples at the next falling edge. For the ends of the listen acknowledge and the talk acknowledge, it also samples one cycle before the expected change and again exactly at it. The address match and the role decode are swept over all 128 values of the seven command lines for two switch settings, with the expected flags computed arithmetically. Directed sequences cover each clear source and its collision with held flags.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int ADDR_W = 5;
  localparam int CMD_W  = 7;

  typedef enum logic [1:0] {
    ROLE_NONE   = 2'b00,
    ROLE_LISTEN = 2'b01,
    ROLE_TALK   = 2'b10,
    ROLE_BOTH   = 2'b11
  } role_code_e;
endpackage

// File: rtl/tl_sync.sv
module tl_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/tl_edge.sv
module tl_edge #(
  parameter bit RISE = 1'b1,
  parameter bit IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic evt
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= IDLE;
    else        prev <= lvl;
  end

  generate
    if (RISE) begin : g_rise
      assign evt = lvl & ~prev;
    end else begin : g_fall
      assign evt = ~lvl & prev;
    end
  endgenerate
endmodule

// File: rtl/tl_decode.sv
module tl_decode
  import tl_pkg::*;
(
  input  logic [ADDR_W-1:0] my_addr,
  input  logic [CMD_W-1:0]  cmd,
  output logic              hit_listen,
  output logic              hit_talk
);
  role_code_e role;
  logic       addr_match;

  always_comb begin
    role       = role_code_e'(cmd[CMD_W-1 -: 2]);
    addr_match = (cmd[ADDR_W-1:0] == my_addr);
    hit_listen = addr_match && (role == ROLE_LISTEN);
    hit_talk   = addr_match && (role == ROLE_TALK);
  end
endmodule

// File: rtl/tl_ack_pulse.sv
module tl_ack_pulse #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic ack_n
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (fire)      cnt <= LOAD;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign ack_n = (cnt == '0);
endmodule

// File: rtl/talk_listen_detect.sv
module talk_listen_detect
  import tl_pkg::*;
#(
  parameter int ACK_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] my_addr_i,
  input  logic [CMD_W-1:0]  cmd_lines_i,
  input  logic              cmd_qual_i,
  input  logic              unlisten_i,
  input  logic              bus_rst_n_i,
  input  logic              untalk_i,
  output logic              listen_o,
  output logic              talk_o,
  output logic              talk_n_o,
  output logic              listen_ack_n_o,
  output logic              talk_ack_n_o
);
  localparam int SW = CMD_W + 4;
  // control bit order in the synchronised vector: qual, unlisten, bus reset, untalk
  localparam logic [SW-1:0] SYNC_RST = SW'(4'b0010);

  logic [SW-1:0]    raw_in, sync_out;
  logic [CMD_W-1:0] cmd_s;
  logic qual_s, unl_s, brst_s, ut_s;
  logic qual_rise, qual_fall, unl_rise, brst_fall, ut_rise;
  logic hit_listen, hit_talk;
  logic clr_listen, clr_talk, set_listen, set_talk;
  logic listen_q, talk_q, talk_n_q, tack_n_q;

  assign raw_in = {cmd_lines_i, cmd_qual_i, unlisten_i, bus_rst_n_i, untalk_i};

  tl_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  assign cmd_s  = sync_out[SW-1:4];
  assign qual_s = sync_out[3];
  assign unl_s  = sync_out[2];
  assign brst_s = sync_out[1];
  assign ut_s   = sync_out[0];

  tl_edge #(.RISE(1'b1), .IDLE(1'b0)) u_qual_r (.clk(clk), .rst_n(rst_n), .lvl(qual_s), .evt(qual_rise));
  tl_edge #(.RISE(1'b0), .IDLE(1'b0)) u_qual_f (.clk(clk), .rst_n(rst_n), .lvl(qual_s), .evt(qual_fall));
  tl_edge #(.RISE(1'b1), .IDLE(1'b0)) u_unl_r  (.clk(clk), .rst_n(rst_n), .lvl(unl_s),  .evt(unl_rise));
  tl_edge #(.RISE(1'b0), .IDLE(1'b1)) u_brst_f (.clk(clk), .rst_n(rst_n), .lvl(brst_s), .evt(brst_fall));
  tl_edge #(.RISE(1'b1), .IDLE(1'b0)) u_ut_r   (.clk(clk), .rst_n(rst_n), .lvl(ut_s),   .evt(ut_rise));

  tl_decode u_dec (
    .my_addr(my_addr_i), .cmd(cmd_s), .hit_listen(hit_listen), .hit_talk(hit_talk)
  );

  // a clear beats a set arriving in the same cycle
  assign clr_listen = unl_rise | brst_fall;
  assign clr_talk   = ut_rise  | brst_fall;
  assign set_listen = qual_rise & hit_listen & ~clr_listen;
  assign set_talk   = qual_rise & hit_talk   & ~clr_talk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      listen_q <= 1'b0;
      talk_q   <= 1'b0;
      talk_n_q <= 1'b1;
      tack_n_q <= 1'b1;
    end else begin
      if (clr_listen)      listen_q <= 1'b0;
      else if (set_listen) listen_q <= 1'b1;

      if (clr_talk) begin
        talk_q   <= 1'b0;
        talk_n_q <= 1'b1;
      end else if (set_talk) begin
        talk_q   <= 1'b1;
        talk_n_q <= 1'b0;
      end

      if (clr_talk || qual_fall) tack_n_q <= 1'b1;
      else if (set_talk)         tack_n_q <= 1'b0;
    end
  end

  tl_ack_pulse #(.CYC(ACK_CYCLES)) u_lack (
    .clk(clk), .rst_n(rst_n), .fire(set_listen), .ack_n(listen_ack_n_o)
  );

  assign listen_o     = listen_q;
  assign talk_o       = talk_q;
  assign talk_n_o     = talk_n_q;
  assign talk_ack_n_o = tack_n_q;
endmodule

// File: rtl/talk_listen_detect_chk.sv
module talk_listen_detect_chk #(
  parameter int ACK_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic listen_o,
  input logic talk_o,
  input logic talk_n_o,
  input logic listen_ack_n_o,
  input logic talk_ack_n_o
);
  localparam int CW = $clog2(ACK_CYCLES + 2);
  logic [CW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  low_run <= '0;
    else if (listen_ack_n_o)     low_run <= '0;
    else if (low_run != '1)      low_run <= low_run + 1'b1;
  end

  assert_talk_complement_R11: assert property (@(posedge clk) disable iff (!rst_n)
    talk_o != talk_n_o);

  assert_listen_ack_with_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(listen_ack_n_o) |-> listen_o);

  assert_listen_ack_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= CW'(ACK_CYCLES));

  assert_listen_set_acks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(listen_o) |-> !listen_ack_n_o);

  assert_talk_set_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(talk_o) |-> (!talk_ack_n_o && !talk_n_o));

  assert_talk_ack_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !talk_ack_n_o |-> talk_o);
endmodule

bind talk_listen_detect talk_listen_detect_chk #(.ACK_CYCLES(ACK_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .listen_o(listen_o), .talk_o(talk_o), .talk_n_o(talk_n_o),
  .listen_ack_n_o(listen_ack_n_o), .talk_ack_n_o(talk_ack_n_o)
);

// File: tb/talk_listen_detect_tb_top.sv
`timescale 1ns/1ps
module talk_listen_detect_tb_top;
  localparam int ACK = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] my_addr = 5'd28;
  logic [6:0] cmd = '0;
  logic       qual = 1'b0, unl = 1'b0, brst_n = 1'b1, ut = 1'b0;
  logic       listen_o, talk_o, talk_n_o, listen_ack_n_o, talk_ack_n_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  talk_listen_detect #(.ACK_CYCLES(ACK)) dut_i (
    .clk(clk), .rst_n(rst_n), .my_addr_i(my_addr), .cmd_lines_i(cmd),
    .cmd_qual_i(qual), .unlisten_i(unl), .bus_rst_n_i(brst_n), .untalk_i(ut),
    .listen_o(listen_o), .talk_o(talk_o), .talk_n_o(talk_n_o),
    .listen_ack_n_o(listen_ack_n_o), .talk_ack_n_o(talk_ack_n_o)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic el, input logic et);
    chk(req, "listen_o", listen_o, el);
    chk(req, "talk_o", talk_o, et);
    chk("R11", "talk_n_o", talk_n_o, ~et);
  endtask

  // drive at a falling edge, return at the falling edge after the third rising edge
  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic command(input logic [6:0] b);
    @(negedge clk); cmd = b; qual = 1'b1;
    settle();
  endtask

  task automatic drop_qual();
    @(negedge clk); qual = 1'b0;
    settle();
  endtask

  task automatic bus_reset();
    @(negedge clk); brst_n = 1'b0;
    settle();
    @(negedge clk); brst_n = 1'b1;
    settle();
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    if (which == 0) unl = 1'b1; else ut = 1'b1;
    settle();
    @(negedge clk); unl = 1'b0; ut = 1'b0;
    settle();
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk_flags("R1", 1'b0, 1'b0);
    chk("R1", "listen_ack_n_o", listen_ack_n_o, 1'b1);
    chk("R1", "talk_ack_n_o", talk_ack_n_o, 1'b1);
    rst_n = 1'b1;
    settle();
    chk_flags("R1", 1'b0, 1'b0);

    // R6: matching listen byte without qualifier
    @(negedge clk); cmd = 7'h3C;
    settle();
    chk_flags("R6", 1'b0, 1'b0);
    chk("R6", "listen_ack_n_o", listen_ack_n_o, 1'b1);

    // R2 R4 R6 sweep: every command value for two switch settings
    for (int s = 0; s < 2; s++) begin
      my_addr = (s == 0) ? 5'd28 : 5'd5;
      for (int b = 0; b < 128; b++) begin
        logic match, el, et;
        match = (b % 32) == my_addr;
        el = match && ((b / 32) == 1);
        et = match && ((b / 32) == 2);
        command(7'(b));
        chk(el ? "R2" : (et ? "R4" : "R6"), "listen_o", listen_o, el);
        chk(et ? "R4" : "R6", "talk_o", talk_o, et);
        chk("R11", "talk_n_o", talk_n_o, ~et);
        chk("R3", "listen_ack_n_o", listen_ack_n_o, ~el);
        chk("R5", "talk_ack_n_o", talk_ack_n_o, ~et);
        if (el) begin
          repeat (ACK - 1) @(posedge clk);
          @(negedge clk);
          chk("R3", "listen_ack_n_o last low", listen_ack_n_o, 1'b0);
          @(posedge clk); @(negedge clk);
          chk("R3", "listen_ack_n_o end", listen_ack_n_o, 1'b1);
        end
        @(negedge clk); qual = 1'b0;
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R10", "talk_ack_n_o before release", talk_ack_n_o, ~et);
        @(posedge clk); @(negedge clk);
        chk("R5", "talk_ack_n_o released", talk_ack_n_o, 1'b1);
        bus_reset();
        chk_flags("R8", 1'b0, 1'b0);
      end
    end

    my_addr = 5'd28;
    // both roles held, then separate clears
    command(7'h3C); drop_qual();
    command(7'h5C); drop_qual();
    chk_flags("R4", 1'b1, 1'b1);
    strobe(0);
    chk_flags("R7", 1'b0, 1'b1);
    strobe(0);
    chk_flags("R7", 1'b0, 1'b1);
    command(7'h3C); drop_qual();
    strobe(1);
    chk_flags("R9", 1'b1, 1'b0);
    bus_reset();
    chk_flags("R8", 1'b0, 1'b0);

    // R9: untalk while talk acknowledge is held by the qualifier
    command(7'h5C);
    chk("R5", "talk_ack_n_o held", talk_ack_n_o, 1'b0);
    @(negedge clk); ut = 1'b1;
    settle();
    chk("R9", "talk_ack_n_o on untalk", talk_ack_n_o, 1'b1);
    chk_flags("R9", 1'b0, 1'b0);
    @(negedge clk); ut = 1'b0; qual = 1'b0;
    settle();

    // R10: unlisten and listen command arriving together, the clear wins
    @(negedge clk); cmd = 7'h3C; qual = 1'b1; unl = 1'b1;
    settle();
    chk_flags("R10", 1'b0, 1'b0);
    chk("R10", "listen_ack_n_o", listen_ack_n_o, 1'b1);
    @(negedge clk); unl = 1'b0; qual = 1'b0;
    settle();

    // R10: listen flag not yet visible after two edges
    @(negedge clk); cmd = 7'h3C; qual = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R10", "listen_o early", listen_o, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R10", "listen_o due", listen_o, 1'b1);
    drop_qual();

    // R8: bus reset with both roles held
    command(7'h5C); drop_qual();
    bus_reset();
    chk_flags("R8", 1'b0, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule